// File: doc/BRIEF.md
# I2C Master Address Phase Controller

This block is a single-master I2C controller for a host that drives it through a small register-style interface. It has a byte register, command bits and a set of status bits. When the bus is free and the host issues a start command, the block produces a start condition. It then shifts out one byte, made of seven address bits and a direction bit, and clocks a ninth acknowledge cycle. At the falling edge of that ninth clock it captures the acknowledge level and raises a one-cycle interrupt. It then parks SCL low until the host lets it go on.

When the slave acknowledges, the block switches its own send/receive role from the direction bit. After that the host either resumes with another byte or asks for a stop condition, which returns the bus to idle. SCL and SDA are open-drain: an output of 1 pulls the line low. The block reads the real line levels back on separate inputs and uses them to track whether the bus is busy. Every bus phase lasts a programmable number of cycles. There is no arbitration and no slave mode.

Top module: `i2c_addr_master`

## Requirements
- R1: After reset, scl_oe=0, sda_oe=0, irq=0, st_resume=1, st_busy=0, st_master=0, st_tx=0 and rd_data=0.
- R2: A start is accepted only from idle, on a wr_ctrl cycle with ctrl_master, ctrl_tx, ctrl_busy and ctrl_resume all 1 while st_busy=0. Any other combination leaves both lines released and st_master at 0.
- R3: Let N = half_cnt+1 cycles. An accepted start drives sda_oe=1 with SCL released for N cycles, starting in the cycle after the accepting write. It then adds scl_oe=1 for N cycles. Every later bit phase also lasts N cycles.
- R4: Each bit has a low phase (scl_oe=1) followed by a high phase (scl_oe=0), and SDA changes only in the low phase. Sent bytes go out most significant bit first; sda_oe=1 sends a 0. In the address byte, bit 7 down to bit 1 are A6..A0 and bit 0 is the direction bit (1 = read).
- R5: On the ninth clock of a sent byte the controller releases SDA. The SDA level at the end of that high phase is stored in st_last_bit, where 0 means acknowledged.
- R6: At the end of the ninth high phase, scl_oe goes to 1. In that same cycle irq is high for exactly one cycle and st_resume drops to 0.
- R7: While st_resume=0, scl_oe stays 1 and sda_oe stays 0.
- R8: After the address byte, an acknowledge (st_last_bit=0) sets st_tx to the inverse of the direction bit. A missing acknowledge leaves st_tx unchanged, and later bytes never change it.
- R9: A write on wr_data is taken only while idle or holding. During start, shifting or stop it is ignored: rd_data and the bits on the wire are unchanged. A write in the same cycle as an accepted start or resume command is taken, and that byte is the one sent.
- R10: st_busy becomes 1 in the cycle after the bus lines show SDA falling while SCL is high. It becomes 0 in the cycle after SDA rises while SCL is high, whoever drives the lines.
- R11: While holding, wr_ctrl with ctrl_resume=1 and ctrl_busy=0 produces a stop in three phases of N cycles each. First SCL and SDA are both low, then SCL is released with SDA still low, then both are released. The block then returns to idle with st_master=0 and st_resume=1.
- R12: While holding, wr_ctrl with ctrl_resume=1 and ctrl_busy=1 runs one more byte in the direction given by st_tx. When receiving, the controller releases SDA for eight bits and loads them into rd_data MSB first at the ninth clock. On that ninth clock it drives SDA low if ctrl_ack_gen was 1 in the resume write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_cnt | input | HALF_W | Bus phase length minus one, in cycles |
| wr_data | input | 1 | Write strobe for the byte register |
| wr_data_byte | input | 8 | Byte to write |
| wr_ctrl | input | 1 | Write strobe for the command bits |
| ctrl_master | input | 1 | Command: master |
| ctrl_tx | input | 1 | Command: send role |
| ctrl_busy | input | 1 | Command: claim the bus (0 while holding requests a stop) |
| ctrl_resume | input | 1 | Command: set the resume flag |
| ctrl_ack_gen | input | 1 | Drive an acknowledge when receiving |
| rd_data | output | 8 | Byte register readout |
| st_master | output | 1 | Master role active |
| st_tx | output | 1 | 1 = sending, 0 = receiving |
| st_busy | output | 1 | Bus busy, as seen on the lines |
| st_resume | output | 1 | 0 while SCL is parked low |
| st_last_bit | output | 1 | SDA level sampled on the last ninth clock |
| irq | output | 1 | One-cycle interrupt at the ninth clock fall |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
A host write to the byte register can fall in the same cycle as a start or resume command. Both are then accepted at one edge, so the shifter must take the incoming byte, not the stale register value. The bench provokes this twice: once with a start and once with a transmit resume, each time with a byte that differs from the stored one. It judges the result bit by bit against the expected SDA pattern and against rd_data afterwards. The opposite case, a write landing mid-byte, is also driven. There the wire pattern and readout must keep the old byte.

// File: rtl/i2cam_pkg.sv
// Shared types and sizes for the I2C master address-phase controller.
package i2cam_pkg;
    localparam int BYTE_W     = 8;
    localparam int FRAME_BITS = BYTE_W + 1;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_STA_A,   // SDA low, SCL high
        PH_STA_B,   // both low
        PH_BIT_LO,  // SCL low, data set up
        PH_BIT_HI,  // SCL released, data held
        PH_HOLD,    // SCL parked low until host resumes
        PH_STO_A,   // both low
        PH_STO_B,   // SCL released, SDA low
        PH_STO_C    // both released
    } phase_t;
endpackage

// File: rtl/i2cam_halftimer.sv
// Phase-length timer. Reloads with half_cnt whenever the phase changes and
// counts down; tick is high once the count reaches zero.
// Assumes: restart is asserted in the cycle the new phase is entered.
module i2cam_halftimer #(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [HALF_W-1:0] half_cnt,
    output logic              tick
);
    logic [HALF_W-1:0] cnt_q;

    // Reload on a phase change, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= half_cnt;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign tick = (cnt_q == '0);
endmodule

// File: rtl/i2cam_busmon.sv
// Bus-busy monitor. Watches the sampled line levels and flags a start
// (SDA falls while SCL high) or a stop (SDA rises while SCL high).
// Assumes: line inputs are already synchronous to clk.
module i2cam_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic bus_busy
);
    logic scl_q, sda_q;
    logic start_det, stop_det;

    // Keep last cycle's line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign start_det = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

    // Busy flag follows the start/stop conditions seen on the lines.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_busy <= 1'b0;
        else if (start_det)
            bus_busy <= 1'b1;
        else if (stop_det)
            bus_busy <= 1'b0;
    end

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> bus_busy); // R10
    AST_BUSY_OFF_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !bus_busy); // R10
endmodule

// File: rtl/i2c_addr_master.sv
// Single-master I2C controller: start condition, address/direction byte,
// acknowledge clock, interrupt, SCL parked low until the host resumes,
// further bytes and a stop. Open-drain lines: *_oe = 1 pulls low.
// Assumes: sole master on the bus; no arbitration, no slave clock stretching.
module i2c_addr_master
    import i2cam_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] half_cnt,
    input  logic              wr_data,
    input  logic [BYTE_W-1:0] wr_data_byte,
    input  logic              wr_ctrl,
    input  logic              ctrl_master,
    input  logic              ctrl_tx,
    input  logic              ctrl_busy,
    input  logic              ctrl_resume,
    input  logic              ctrl_ack_gen,
    output logic [BYTE_W-1:0] rd_data,
    output logic              st_master,
    output logic              st_tx,
    output logic              st_busy,
    output logic              st_resume,
    output logic              st_last_bit,
    output logic              irq,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe
);
    localparam int CNT_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    phase_t            ph_q, ph_nx;
    logic [CNT_W-1:0]  bit_q;
    logic [BYTE_W-1:0] sh_q, data_q, src_byte;
    logic tx_q, master_q, resume_q, ack_gen_q, addr_q, rw_q, lrb_q, irq_q;
    logic tick, bus_busy, restart, last_bit, host_win;
    logic start_ok, cont_ok, stop_ok, data_ok, bit_end;

    i2cam_halftimer #(.HALF_W(HALF_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .half_cnt(half_cnt), .tick(tick)
    );

    i2cam_busmon u_busmon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .bus_busy(bus_busy)
    );

    assign last_bit = (bit_q == LAST_BIT);
    assign host_win = (ph_q == PH_IDLE) || (ph_q == PH_HOLD);
    assign start_ok = wr_ctrl && ctrl_master && ctrl_tx && ctrl_busy && ctrl_resume
                      && !bus_busy && (ph_q == PH_IDLE);
    assign cont_ok  = wr_ctrl && ctrl_resume && ctrl_busy && (ph_q == PH_HOLD);
    assign stop_ok  = wr_ctrl && ctrl_resume && !ctrl_busy && (ph_q == PH_HOLD);
    assign data_ok  = wr_data && host_win;
    assign src_byte = wr_data ? wr_data_byte : data_q;
    assign bit_end  = (ph_q == PH_BIT_HI) && tick;
    assign restart  = (ph_nx != ph_q);

    // Phase sequencing: host commands leave idle/hold, timer ticks elsewhere.
    always_comb begin
        ph_nx = ph_q;
        case (ph_q)
            PH_IDLE:   if (start_ok) ph_nx = PH_STA_A;
            PH_STA_A:  if (tick) ph_nx = PH_STA_B;
            PH_STA_B:  if (tick) ph_nx = PH_BIT_LO;
            PH_BIT_LO: if (tick) ph_nx = PH_BIT_HI;
            PH_BIT_HI: if (tick) ph_nx = last_bit ? PH_HOLD : PH_BIT_LO;
            PH_HOLD:   if (cont_ok) ph_nx = PH_BIT_LO;
                       else if (stop_ok) ph_nx = PH_STO_A;
            PH_STO_A:  if (tick) ph_nx = PH_STO_B;
            PH_STO_B:  if (tick) ph_nx = PH_STO_C;
            PH_STO_C:  if (tick) ph_nx = PH_IDLE;
            default:   ph_nx = PH_IDLE;
        endcase
    end

    // Phase register and the one-cycle interrupt at the ninth clock fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            irq_q <= 1'b0;
        end else begin
            ph_q  <= ph_nx;
            irq_q <= bit_end && last_bit;
        end
    end

    // Shifter and bit counter: load at start/resume, shift at each high end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            bit_q <= '0;
        end else if (start_ok || cont_ok) begin
            sh_q  <= src_byte;
            bit_q <= '0;
        end else if (bit_end && !last_bit) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
            bit_q <= bit_q + 1'b1;
        end
    end

    // Byte register: host writes in idle/hold, received byte at ninth clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (data_ok)
            data_q <= wr_data_byte;
        else if (bit_end && last_bit && !tx_q)
            data_q <= sh_q;
    end

    // Control and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_q  <= 1'b0;
            tx_q      <= 1'b0;
            resume_q  <= 1'b1;
            ack_gen_q <= 1'b0;
            addr_q    <= 1'b0;
            rw_q      <= 1'b0;
            lrb_q     <= 1'b0;
        end else begin
            if (wr_ctrl && host_win)
                ack_gen_q <= ctrl_ack_gen;
            if (start_ok) begin
                master_q <= 1'b1;
                tx_q     <= 1'b1;
                resume_q <= 1'b1;
                addr_q   <= 1'b1;
                rw_q     <= src_byte[0];
            end
            if (cont_ok || stop_ok)
                resume_q <= 1'b1;
            if (bit_end && last_bit) begin
                lrb_q    <= sda_i;
                resume_q <= 1'b0;
                addr_q   <= 1'b0;
                if (addr_q && !sda_i)
                    tx_q <= ~rw_q;
            end
            if ((ph_q == PH_STO_C) && tick)
                master_q <= 1'b0;
        end
    end

    // Open-drain line drive per phase.
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        case (ph_q)
            PH_STA_A: sda_oe = 1'b1;
            PH_STA_B, PH_STO_A: begin
                scl_oe = 1'b1;
                sda_oe = 1'b1;
            end
            PH_STO_B: sda_oe = 1'b1;
            PH_HOLD:  scl_oe = 1'b1;
            PH_BIT_LO, PH_BIT_HI: begin
                scl_oe = (ph_q == PH_BIT_LO);
                sda_oe = last_bit ? (~tx_q & ack_gen_q) : (tx_q & ~sh_q[BYTE_W-1]);
            end
            default: ;
        endcase
    end

    assign rd_data     = data_q;
    assign st_master   = master_q;
    assign st_tx       = tx_q;
    assign st_busy     = bus_busy;
    assign st_resume   = resume_q;
    assign st_last_bit = lrb_q;
    assign irq         = irq_q;

    AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_STA_A && $past(ph_q) == PH_IDLE) |-> !$past(bus_busy)); // R2
    AST_SDA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_BIT_HI && $past(ph_q) == PH_BIT_HI) |-> $stable(sda_oe)); // R4
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R6
    AST_IRQ_CLEARS_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !st_resume); // R6
    AST_SCL_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (master_q && !resume_q) |-> (scl_oe && !sda_oe)); // R7
    AST_TX_KEPT_ON_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && st_last_bit) |-> (tx_q == $past(tx_q))); // R8
    AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_BIT_LO && $past(ph_q) == PH_BIT_LO) |-> $stable(data_q)); // R9
endmodule

// File: tb/tb_i2c_addr_master.sv
`timescale 1ns/1ps
module tb_i2c_addr_master;
    localparam int HALF_W = 8;
    localparam int HV     = 2;
    localparam int NPH    = HV + 1;

    typedef struct packed {
        logic scl;  // expected scl_oe
        logic sda;  // expected sda_oe
        logic irq;  // expected irq
        logic bb;   // expected st_busy
        logic slv;  // bench slave pulls SDA low this cycle
    } ent_t;

    ent_t q[$];
    ent_t rest;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [HALF_W-1:0] half_cnt = HALF_W'(HV);
    logic wr_data = 1'b0, wr_ctrl = 1'b0;
    logic [7:0] wr_data_byte = 8'h00;
    logic ctrl_master = 0, ctrl_tx = 0, ctrl_busy = 0, ctrl_resume = 0, ctrl_ack_gen = 0;
    logic [7:0] rd_data;
    logic st_master, st_tx, st_busy, st_resume, st_last_bit, irq;
    logic scl_oe, sda_oe, scl_i, sda_i;
    logic slave_low = 1'b0, ext_scl = 1'b0, ext_sda = 1'b0;
    logic mon_on = 1'b0;
    int n_chk = 0, n_err = 0;

    assign scl_i = ~(scl_oe | ext_scl);
    assign sda_i = ~(sda_oe | slave_low | ext_sda);

    always #2 clk = ~clk;

    i2c_addr_master #(.HALF_W(HALF_W)) dut (
        .clk(clk), .rst_n(rst_n), .half_cnt(half_cnt),
        .wr_data(wr_data), .wr_data_byte(wr_data_byte),
        .wr_ctrl(wr_ctrl), .ctrl_master(ctrl_master), .ctrl_tx(ctrl_tx),
        .ctrl_busy(ctrl_busy), .ctrl_resume(ctrl_resume), .ctrl_ack_gen(ctrl_ack_gen),
        .rd_data(rd_data), .st_master(st_master), .st_tx(st_tx), .st_busy(st_busy),
        .st_resume(st_resume), .st_last_bit(st_last_bit), .irq(irq),
        .scl_i(scl_i), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    task automatic chk(input string req, input int act, input int exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp_v, $time);
        end
    endtask

    task automatic push_n(input logic s, input logic d, input logic i,
                          input logic b, input logic v, input int n);
        for (int k = 0; k < n; k++) q.push_back({s, d, i, b, v});
    endtask

    // Start condition (R3): first cycle the busy flag is still 0.
    task automatic push_start();
        push_n(0, 1, 0, 0, 0, 1);
        push_n(0, 1, 0, 1, 0, NPH - 1);
        push_n(1, 1, 0, 1, 0, NPH);
    endtask

    // One byte plus acknowledge clock, then the parked-SCL hold (R4-R7, R12).
    task automatic push_byte(input logic [7:0] b, input logic tx, input logic [7:0] sb,
                             input logic cack, input logic sack);
        for (int i = 7; i >= 0; i--) begin
            logic c, v;
            c = tx ? ~b[i] : 1'b0;
            v = tx ? 1'b0 : ~sb[i];
            push_n(1, c, 0, 1, v, NPH);
            push_n(0, c, 0, 1, v, NPH);
        end
        push_n(1, tx ? 1'b0 : cack, 0, 1, tx ? sack : 1'b0, NPH);
        push_n(0, tx ? 1'b0 : cack, 0, 1, tx ? sack : 1'b0, NPH);
        push_n(1, 0, 1, 1, 0, 1);
        rest = {1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
    endtask

    // Stop condition (R11): busy drops one cycle after SDA rises.
    task automatic push_stop();
        push_n(1, 1, 0, 1, 0, NPH);
        push_n(0, 1, 0, 1, 0, NPH);
        push_n(0, 0, 0, 1, 0, 1);
        push_n(0, 0, 0, 0, 0, NPH - 1);
        rest = '0;
    endtask

    task automatic cmd(input logic m, input logic t, input logic b, input logic r,
                       input logic a, input logic dv, input logic [7:0] d);
        @(negedge clk);
        wr_ctrl = 1'b1; ctrl_master = m; ctrl_tx = t; ctrl_busy = b;
        ctrl_resume = r; ctrl_ack_gen = a; wr_data = dv; wr_data_byte = d;
    endtask

    task automatic release_in();
        @(negedge clk);
        wr_ctrl = 1'b0; wr_data = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Per-cycle comparison against the reference waveform (R3 R4 R6 R7 R10).
    always @(posedge clk) begin : cmp
        ent_t e;
        #1;
        if (mon_on) begin
            if (q.size() != 0) e = q.pop_front();
            else e = rest;
            slave_low = e.slv;
            chk("R3/R4/R6/R7/R10 wave {scl,sda,irq,busy}",
                {28'd0, scl_oe, sda_oe, irq, st_busy}, {28'd0, e.scl, e.sda, e.irq, e.bb});
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rest = '0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 scl_oe", scl_oe, 0);
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 irq", irq, 0);
        chk("R1 st_resume", st_resume, 1);
        chk("R1 st_busy", st_busy, 0);
        chk("R1 st_master", st_master, 0);
        chk("R1 st_tx", st_tx, 0);
        chk("R1 rd_data", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;

        // R2: incomplete start command is refused (resume bit 0)
        cmd(1, 1, 1, 0, 0, 0, 8'h00);
        release_in();
        repeat (8) @(negedge clk);
        chk("R2 st_master after refused start", st_master, 0);

        // R10 + R2: another device claims the bus, start must be refused
        mon_on = 1'b0;
        @(negedge clk);
        ext_sda = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 busy after foreign start", st_busy, 1);
        cmd(1, 1, 1, 1, 0, 0, 8'h00);
        release_in();
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R2 no drive while busy", {scl_oe, sda_oe}, 0);
        end
        chk("R2 st_master while busy", st_master, 0);
        ext_sda = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 busy cleared after foreign stop", st_busy, 0);
        mon_on = 1'b1;

        // Address 0x52 read (byte 0xA5), slave acknowledges
        @(negedge clk);
        wr_data = 1'b1; wr_data_byte = 8'hA5;
        @(negedge clk);
        wr_data = 1'b0;
        cmd(1, 1, 1, 1, 1, 0, 8'h00);
        push_start();
        push_byte(8'hA5, 1'b1, 8'h00, 1'b0, 1'b1);
        release_in();
        repeat (10) @(negedge clk);
        wr_data = 1'b1; wr_data_byte = 8'h3C;   // R9: ignored mid-byte
        @(negedge clk);
        wr_data = 1'b0;
        drain();
        chk("R5 ack captured", st_last_bit, 0);
        chk("R6 resume cleared", st_resume, 0);
        chk("R8 switched to receive on ack of read", st_tx, 0);
        chk("R9 mid-byte write ignored", rd_data, 8'hA5);
        chk("R2 st_master after start", st_master, 1);
        repeat (20) @(negedge clk);               // R7 hold observed by cmp

        // R12: receive one byte 0x6B, controller acknowledges
        cmd(1, 0, 1, 1, 1, 0, 8'h00);
        push_byte(8'h00, 1'b0, 8'h6B, 1'b1, 1'b0);
        release_in();
        drain();
        chk("R12 received byte", rd_data, 8'h6B);
        chk("R12 own ack seen on line", st_last_bit, 0);
        chk("R8 data byte keeps role", st_tx, 0);

        // R11: stop
        cmd(1, 0, 0, 1, 0, 0, 8'h00);
        push_stop();
        release_in();
        drain();
        chk("R11 st_master after stop", st_master, 0);
        chk("R11 st_resume after stop", st_resume, 1);
        chk("R11 st_busy after stop", st_busy, 0);

        // R9 same-cycle write with start; read request 0x5B, no acknowledge
        cmd(1, 1, 1, 1, 0, 1, 8'h5B);
        push_start();
        push_byte(8'h5B, 1'b1, 8'h00, 1'b0, 1'b0);
        release_in();
        drain();
        chk("R5 nack captured", st_last_bit, 1);
        chk("R8 role kept on nack", st_tx, 1);
        chk("R9 same-cycle byte stored", rd_data, 8'h5B);

        // R12 transmit resume with same-cycle byte 0xC3, slave acknowledges
        cmd(1, 1, 1, 1, 0, 1, 8'hC3);
        push_byte(8'hC3, 1'b1, 8'h00, 1'b0, 1'b1);
        release_in();
        drain();
        chk("R9 resume byte stored", rd_data, 8'hC3);
        chk("R5 data ack captured", st_last_bit, 0);
        chk("R8 role unchanged on data byte", st_tx, 1);

        cmd(1, 1, 0, 1, 0, 0, 8'h00);
        push_stop();
        release_in();
        drain();
        chk("R11 idle after second stop", st_master, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule